// File: doc/BRIEF.md
# Calendar Clock Timekeeping Core

This block holds a wall-clock time and calendar date (seconds, minutes, hours, weekday, day of month, month and a two-digit year) and moves them forward by one second each time its tick input pulses. A mode register chooses whether every field is stored as packed BCD or as plain binary. It also chooses whether hours are kept on a 24-hour dial or on a 12-hour dial, where the top bit of the hour byte marks the afternoon. Three alarm bytes for second, minute and hour are compared against the time after every update. The alarm event fires only when all three agree. An alarm byte whose two top bits are both set matches any value.

Each tick starts an update window. A busy flag (`uip`) is raised for a fixed number of lead cycles plus one update cycle, and time values read inside this window are not meaningful. A one-cycle completion pulse follows the window. Register writes that arrive while the window is open are held in a single slot and applied in the completion cycle, so they land on top of the fresh update. A freeze bit in the mode register stops ticks from starting updates, which lets software load a consistent time.

Top module: `rtcCore`

## Requirements
- R1: In BCD mode, seconds count 00h..59h. From 59h they wrap to 00h and carry into minutes, which behave the same way and carry into hours.
- R2: With mode bit 1 set (binary), fields hold plain binary values, and seconds wrap from 3Bh to 00h with a carry into minutes.
- R3: With mode bit 2 set (24-hour), hours run 0..23. An update from 23:59:59 gives hour 0 and advances the date.
- R4: With mode bit 2 clear (12-hour), hours run 1..12 with bit 7 set for PM. 11:59:59 AM (11h) goes to 92h, 12:59:59 PM (92h) goes to 81h, and 11:59:59 PM (91h) goes to 12h with a date advance.
- R5: The day of month wraps to 1 after the month's last day (30 for months 4, 6, 9 and 11, 31 for the others, February 29 when the year is divisible by 4 and 28 otherwise). Month wraps 12 to 1 with a year carry, and year wraps 99 to 0.
- R6: The weekday runs 1..7 and steps from 7 to 1 on each date advance.
- R7: `alarmHit` pulses with `updateDone` only when the alarm second, minute and hour bytes each equal their time field or have bits 7:6 equal to 11b.
- R8: While mode bit 0 (freeze) is 1, ticks are ignored: `uip` stays low and the time does not change.
- R9: The cycle after a tick is sampled, `uip` goes high for UIP_LEAD+1 cycles. The time changes at the end of that window, and `updateDone` is high for exactly the next cycle.
- R10: A write made while `uip` is high is applied in the `updateDone` cycle, after the update, so its value is what is read back.
- R11: Bit 7 of the seconds byte (address 0) is read-only and always reads 0.
- R12: After reset, time is 00:00:00 on weekday 1, date 1, month 1, year 0. The mode byte (address 12) reads 04h (BCD, 24-hour, not frozen), and `uip` is low.
- R13: Address map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 8/9/10 alarm second/minute/hour, 12 mode. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second pulse, one clock wide |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| uip | output | 1 | Update-in-progress flag |
| updateDone | output | 1 | One-cycle pulse when an update completes |
| alarmHit | output | 1 | Alarm event, coincident with `updateDone` |

## Verification
The bench builds the core with UIP_LEAD set to 2, a shorter lead window than the default. This keeps every tick to five cycles, so many carry chains (hour, day, month, leap February, year wrap) fit in one short run. With that setting the exact busy-window length of three cycles is checked against the formula, not against a hard-wired default. It also opens a write slot inside the window, which exercises deferral while the update cycle is still ahead.

// File: rtl/rtcPkg.sv
package rtcPkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NUM_ALM = 3;

  localparam logic [ADDR_W-1:0] ADR_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_HOUR = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_DOW  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_DATE = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_MON  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_YEAR = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_ALM0 = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_MODE = 4'd12;

  typedef struct packed {
    logic              doUpdate;
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } rtcStrobe_t;

  function automatic logic [7:0] decodeVal(input logic [7:0] v, input logic bcd);
    return bcd ? (8'(v[7:4]) * 8'd10 + 8'(v[3:0])) : v;
  endfunction

  function automatic logic [7:0] encodeVal(input logic [7:0] v, input logic bcd);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bcd ? {tens[3:0], ones[3:0]} : v;
  endfunction

  function automatic logic [7:0] hourTo24(input logic [7:0] raw, input logic bcd, input logic h24);
    logic [7:0] h;
    if (h24) return decodeVal(raw, bcd);
    h = decodeVal(raw & 8'h7F, bcd);
    if (h == 8'd12) h = 8'd0;
    return raw[7] ? h + 8'd12 : h;
  endfunction

  function automatic logic [7:0] hourFrom24(input logic [7:0] h, input logic bcd, input logic h24);
    logic [7:0] h12;
    if (h24) return encodeVal(h, bcd);
    h12 = (h >= 8'd12) ? h - 8'd12 : h;
    if (h12 == 8'd0) h12 = 8'd12;
    return encodeVal(h12, bcd) | ((h >= 8'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                      return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int UIP_LEAD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              freeze,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output rtcStrobe_t        stb,
  output logic              uip,
  output logic              updateDone
);
  localparam int CNT_W = $clog2(UIP_LEAD + 1);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(UIP_LEAD - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_UPD, S_DONE} ctrlState_t;

  ctrlState_t        state;
  logic [CNT_W-1:0]  leadCnt;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic              busy;

  assign busy = (state == S_LEAD) || (state == S_UPD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      leadCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (tick && !freeze) begin
          state   <= S_LEAD;
          leadCnt <= '0;
        end
        S_LEAD: if (leadCnt == LEAD_LAST) state <= S_UPD;
                else leadCnt <= leadCnt + 1'b1;
        S_UPD:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (wrEn && (busy || pendValid)) begin
      pendValid <= 1'b1;
      pendAddr  <= wrAddr;
      pendData  <= wrData;
    end else if (!busy) begin
      pendValid <= 1'b0;
    end
  end

  always_comb begin
    stb.doUpdate = (state == S_UPD);
    stb.wrEn     = !busy && (pendValid || wrEn);
    stb.wrAddr   = pendValid ? pendAddr : wrAddr;
    stb.wrData   = pendValid ? pendData : wrData;
  end

  assign uip        = busy;
  assign updateDone = (state == S_DONE);

  p_uip_after_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uip) |-> $past(tick));
  p_done_follows_uip_r9: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |-> $past(uip));
  p_freeze_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !busy) |=> !$rose(uip));
  p_no_write_in_update_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.doUpdate |-> !stb.wrEn);
endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        stb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              freeze,
  output logic              alarmMatch
);
  logic [7:0] secR, minR, hourR, dowR, dateR, monR, yearR;
  logic [2:0] modeR;
  logic [7:0] almR [NUM_ALM];
  logic [7:0] curF [NUM_ALM];
  logic [NUM_ALM-1:0] almHit;

  logic isBcd, is24;
  logic [7:0] sB, mB, hB, dB, moB, yB, lenB;
  logic cMin, cHr, cDay, cMon, cYr;
  logic [7:0] nSec, nMin, nHour, nDow, nDate, nMon, nYear;

  assign freeze = modeR[0];
  assign isBcd  = !modeR[1];
  assign is24   = modeR[2];

  always_comb begin
    sB   = decodeVal(secR, isBcd);
    mB   = decodeVal(minR, isBcd);
    hB   = hourTo24(hourR, isBcd, is24);
    dB   = decodeVal(dateR, isBcd);
    moB  = decodeVal(monR, isBcd);
    yB   = decodeVal(yearR, isBcd);
    lenB = monthDays(moB, yB);
    cMin = (sB >= 8'd59);
    cHr  = cMin && (mB >= 8'd59);
    cDay = cHr && (hB >= 8'd23);
    cMon = cDay && (dB >= lenB);
    cYr  = cMon && (moB >= 8'd12);
    nSec  = encodeVal(cMin ? 8'd0 : sB + 8'd1, isBcd);
    nMin  = cMin ? encodeVal(cHr ? 8'd0 : mB + 8'd1, isBcd) : minR;
    nHour = cHr ? hourFrom24(cDay ? 8'd0 : hB + 8'd1, isBcd, is24) : hourR;
    nDow  = cDay ? ((dowR >= 8'd7) ? 8'd1 : dowR + 8'd1) : dowR;
    nDate = cDay ? encodeVal(cMon ? 8'd1 : dB + 8'd1, isBcd) : dateR;
    nMon  = cMon ? encodeVal(cYr ? 8'd1 : moB + 8'd1, isBcd) : monR;
    nYear = cYr ? encodeVal((yB >= 8'd99) ? 8'd0 : yB + 8'd1, isBcd) : yearR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR <= 8'h00; minR <= 8'h00; hourR <= 8'h00; dowR <= 8'h01;
      dateR <= 8'h01; monR <= 8'h01; yearR <= 8'h00; modeR <= 3'b100;
    end else if (stb.doUpdate) begin
      secR <= nSec; minR <= nMin; hourR <= nHour; dowR <= nDow;
      dateR <= nDate; monR <= nMon; yearR <= nYear;
    end else if (stb.wrEn) begin
      case (stb.wrAddr)
        ADR_SEC:  secR  <= {1'b0, stb.wrData[6:0]};
        ADR_MIN:  minR  <= stb.wrData;
        ADR_HOUR: hourR <= stb.wrData;
        ADR_DOW:  dowR  <= stb.wrData;
        ADR_DATE: dateR <= stb.wrData;
        ADR_MON:  monR  <= stb.wrData;
        ADR_YEAR: yearR <= stb.wrData;
        ADR_MODE: modeR <= stb.wrData[2:0];
        default: ;
      endcase
    end
  end

  assign curF[0] = secR;
  assign curF[1] = minR;
  assign curF[2] = hourR;

  for (genvar g = 0; g < NUM_ALM; g++) begin : gAlarm
    localparam logic [ADDR_W-1:0] MY_ADDR = ADR_ALM0 + ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (!rstN) almR[g] <= 8'h00;
      else if (stb.wrEn && !stb.doUpdate && stb.wrAddr == MY_ADDR) almR[g] <= stb.wrData;
    end
    assign almHit[g] = (almR[g][7:6] == 2'b11) || (almR[g] == curF[g]);
  end

  assign alarmMatch = &almHit;

  always_comb begin
    case (rdAddr)
      ADR_SEC:  rdData = secR;
      ADR_MIN:  rdData = minR;
      ADR_HOUR: rdData = hourR;
      ADR_DOW:  rdData = dowR;
      ADR_DATE: rdData = dateR;
      ADR_MON:  rdData = monR;
      ADR_YEAR: rdData = yearR;
      ADR_ALM0: rdData = almR[0];
      ADR_ALM0 + 4'd1: rdData = almR[1];
      ADR_ALM0 + 4'd2: rdData = almR[2];
      ADR_MODE: rdData = {5'b0, modeR};
      default:  rdData = 8'h00;
    endcase
  end

  p_quiet_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.doUpdate && !stb.wrEn) |=> ($stable(secR) && $stable(minR) && $stable(hourR)));
  p_sec_msb_r11: assert property (@(posedge clk) disable iff (!rstN)
    secR[7] == 1'b0);
  p_update_moves_sec_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.doUpdate |=> !$stable(secR));
endmodule

// File: rtl/rtcCore.sv
module rtcCore
  import rtcPkg::*;
#(
  parameter int UIP_LEAD = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       uip,
  output logic       updateDone,
  output logic       alarmHit
);
  rtcStrobe_t stb;
  logic       freeze;
  logic       alarmMatch;

  rtcCtrl #(.UIP_LEAD(UIP_LEAD)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .freeze(freeze),
    .wrEn(wrEn), .wrAddr(addr), .wrData(wrData),
    .stb(stb), .uip(uip), .updateDone(updateDone)
  );

  rtcDatapath i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(addr),
    .rdData(rdData), .freeze(freeze), .alarmMatch(alarmMatch)
  );

  assign alarmHit = updateDone && alarmMatch;
endmodule

// File: tb/test_rtcCore.sv
module test_rtcCore;
  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 2;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic uip, updateDone, alarmHit;
  int nChecks = 0, nErrors = 0;
  bit finished = 0;

  rtcCore #(.UIP_LEAD(LEAD)) i_rtcCore (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .uip(uip), .updateDone(updateDone),
    .alarmHit(alarmHit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdData, exp);
  endtask

  task automatic doTick(input bit doWr, input logic [3:0] wa, input logic [7:0] wd,
                        output int uipCnt, output bit done, output bit alm);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (doWr) begin addr = wa; wrData = wd; wrEn = 1'b1; end
    uipCnt = 0; done = 0; alm = 0;
    for (int i = 0; i < 12 && !done; i++) begin
      if (uip) uipCnt++;
      if (updateDone) begin done = 1; alm = alarmHit; end
      @(negedge clk); wrEn = 1'b0;
    end
  endtask

  task automatic setClock(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  task automatic setCal(input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
    wr(4'd3, dw); wr(4'd4, dt); wr(4'd5, mo); wr(4'd6, yr);
  endtask

  task automatic testReset();
    rdCheck("R12 sec", 4'd0, 8'h00);
    rdCheck("R12 hour", 4'd2, 8'h00);
    rdCheck("R12 dow", 4'd3, 8'h01);
    rdCheck("R12 date", 4'd4, 8'h01);
    rdCheck("R12 month", 4'd5, 8'h01);
    rdCheck("R12 mode", 4'd12, 8'h04);
    check("R12 uip", uip, 0);
    rdCheck("R13 unmapped", 4'd7, 8'h00);
  endtask

  task automatic testBcdCarry();
    int u; bit d, a;
    setClock(8'h10, 8'h59, 8'h58);
    doTick(0, 0, 0, u, d, a);
    check("R9 uip length", u, LEAD + 1);
    check("R9 done pulse", d, 1);
    rdCheck("R1 sec step", 4'd0, 8'h59);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R1 sec wrap", 4'd0, 8'h00);
    rdCheck("R1 min wrap", 4'd1, 8'h00);
    rdCheck("R1 hour carry", 4'd2, 8'h11);
  endtask

  task automatic testSecMsb();
    wr(4'd0, 8'hA5);
    rdCheck("R11 sec bit7", 4'd0, 8'h25);
  endtask

  task automatic testBinary();
    int u; bit d, a;
    wr(4'd12, 8'h06);
    setClock(8'd5, 8'h05, 8'h3B);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R2 bin sec wrap", 4'd0, 8'h00);
    rdCheck("R2 bin min", 4'd1, 8'h06);
    wr(4'd0, 8'h09);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R2 bin no bcd skip", 4'd0, 8'h0A);
    wr(4'd12, 8'h04);
  endtask

  task automatic testDayRoll();
    int u; bit d, a;
    setClock(8'h23, 8'h59, 8'h59);
    setCal(8'h07, 8'h15, 8'h06, 8'h10);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R3 hour 0", 4'd2, 8'h00);
    rdCheck("R3 date adv", 4'd4, 8'h16);
    rdCheck("R6 dow wrap", 4'd3, 8'h01);
  endtask

  task automatic testTwelveHour();
    int u; bit d, a;
    wr(4'd12, 8'h00);
    setCal(8'h02, 8'h10, 8'h03, 8'h10);
    setClock(8'h11, 8'h59, 8'h59);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R4 11am to 12pm", 4'd2, 8'h92);
    setClock(8'h92, 8'h59, 8'h59);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R4 12pm to 1pm", 4'd2, 8'h81);
    setClock(8'h91, 8'h59, 8'h59);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R4 11pm to 12am", 4'd2, 8'h12);
    rdCheck("R4 date adv", 4'd4, 8'h11);
    rdCheck("R6 dow step", 4'd3, 8'h03);
    wr(4'd12, 8'h04);
  endtask

  task automatic oneDateCase(input string req, input logic [7:0] dt, input logic [7:0] mo,
                             input logic [7:0] yr, input logic [7:0] eDt,
                             input logic [7:0] eMo, input logic [7:0] eYr);
    int u; bit d, a;
    setClock(8'h23, 8'h59, 8'h59);
    setCal(8'h01, dt, mo, yr);
    doTick(0, 0, 0, u, d, a);
    rdCheck(req, 4'd4, eDt);
    rdCheck(req, 4'd5, eMo);
    rdCheck(req, 4'd6, eYr);
  endtask

  task automatic testDates();
    oneDateCase("R5 feb common", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
    oneDateCase("R5 feb leap", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
    oneDateCase("R5 30-day month", 8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
    oneDateCase("R5 31-day month", 8'h30, 8'h05, 8'h24, 8'h31, 8'h05, 8'h24);
    oneDateCase("R5 year wrap", 8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic testAlarm();
    int u; bit d, a;
    setClock(8'h10, 8'h20, 8'h29);
    wr(4'd8, 8'h30); wr(4'd9, 8'h20); wr(4'd10, 8'h10);
    doTick(0, 0, 0, u, d, a);
    check("R7 exact match", a, 1);
    doTick(0, 0, 0, u, d, a);
    check("R7 no match", a, 0);
    wr(4'd8, 8'h31); wr(4'd10, 8'h11);
    setClock(8'h10, 8'h20, 8'h30);
    doTick(0, 0, 0, u, d, a);
    check("R7 hour differs", a, 0);
    wr(4'd9, 8'hC0); wr(4'd10, 8'hFF);
    setClock(8'h05, 8'h44, 8'h30);
    doTick(0, 0, 0, u, d, a);
    check("R7 wildcard", a, 1);
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);
  endtask

  task automatic testFreeze();
    int u; bit d, a;
    setClock(8'h01, 8'h02, 8'h03);
    wr(4'd12, 8'h05);
    doTick(0, 0, 0, u, d, a);
    check("R8 no uip", u, 0);
    check("R8 no done", d, 0);
    rdCheck("R8 time held", 4'd0, 8'h03);
    wr(4'd12, 8'h04);
    doTick(0, 0, 0, u, d, a);
    rdCheck("R8 resumes", 4'd0, 8'h04);
  endtask

  task automatic testDeferred();
    int u; bit d, a;
    setClock(8'h01, 8'h02, 8'h10);
    doTick(1, 4'd0, 8'h30, u, d, a);
    check("R10 done seen", d, 1);
    rdCheck("R10 write after update", 4'd0, 8'h30);
    rdCheck("R10 min untouched", 4'd1, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBcdCarry();
    testSecMsb();
    testBinary();
    testDayRoll();
    testTwelveHour();
    testDates();
    testAlarm();
    testFreeze();
    testDeferred();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule